// File: doc/BRIEF.md
# Mixed-Latency Execute Sequencer

This block is the control heart of a pipeline execute stage that handles two kinds of operation. Short operations (add, subtract, exclusive-or) are evaluated combinationally and their result leaves the stage in the same cycle the operation arrives. Long operations (a multiply-accumulate) are handed to a small internal unit built as three steps with two-entry buffers between them. The stage then raises a busy flag and holds until the long result comes back.

Operations arrive on a valid/ready channel and results leave on a second valid/ready channel. The stage consumes an operation only when it can finish it or launch it. While busy it refuses new work. A result that downstream is not ready for is held in place, never dropped.

The controller has two states. `ST_READY` is not waiting and `ST_WAIT` is waiting on the long unit. The transition ISSUE goes from `ST_READY` to `ST_WAIT` when a long operation is launched. The transition RETIRE goes from `ST_WAIT` to `ST_READY` when the long result is handed off. In every other cycle the state holds.

Top module: `mixed_exec_stage`

## Requirements
- R1: After reset, `busy` and `res_valid` are low while `op_valid` is low.
- R2: In `ST_READY`, an operation with code 2'b00 (add), 2'b01 (subtract a minus b) or 2'b10 (xor) presents `res_valid` high with its result in the same cycle. Results are modulo 2^DATA_W.
- R3: In `ST_READY`, when the code is short, `op_ready` equals `res_ready`. A short operation is consumed only when its result is taken.
- R4: In `ST_READY`, code 2'b11 (long) gives `op_ready` high. When it is valid it is launched with `res_valid` low in that cycle, and `busy` is high from the next cycle.
- R5: While `busy` is high, `op_ready` is low.
- R6: The long result is a*b + a + 1 modulo 2^DATA_W. `res_valid` rises two cycles after the launch cycle.
- R7: While `busy` is high, a presented long result stays valid and unchanged for as long as `res_ready` is low.
- R8: `busy` falls in the cycle after the long result is taken with `res_ready` high, and it stays high until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is offered |
| op_ready | output | 1 | The offered operation is consumed this cycle |
| op_code | input | 2 | 00 add, 01 sub, 10 xor, 11 long multiply-accumulate |
| op_a | input | DATA_W | First operand |
| op_b | input | DATA_W | Second operand |
| res_valid | output | 1 | A result is presented |
| res_ready | input | 1 | Downstream takes the result |
| res_data | output | DATA_W | Result value |
| busy | output | 1 | A long operation is in flight |

## Verification
Two events can coincide in one cycle. A short result can be handed off in the same cycle the next operation is accepted. A long result can be retired in the cycle just before a new operation arrives. The bench provokes both with back-to-back operations of mixed kinds and with `res_ready` pulled low on chosen cycles, including stalls on a presented long result. A behavioural model tracks busy and cycles since launch, and every clock it predicts `op_ready`, `res_valid`, `res_data` and `busy`, so a lost, duplicated or early result shows up in the cycle it happens.

// File: rtl/mxs_pkg.sv
package mxs_pkg;
    typedef enum logic [1:0] {
        OPC_ADD  = 2'b00,
        OPC_SUB  = 2'b01,
        OPC_XOR  = 2'b10,
        OPC_LONG = 2'b11
    } opc_e;

    typedef enum logic {
        ST_READY = 1'b0,
        ST_WAIT  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/mxs_fifo.sv
module mxs_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enq,
    input  logic [WIDTH-1:0] din,
    output logic             full,
    input  logic             deq,
    output logic [WIDTH-1:0] dout,
    output logic             empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CMAX = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wptr, rptr;
    logic [CW-1:0]    count;

    assign full  = (count == CMAX);
    assign empty = (count == '0);
    assign dout  = mem[rptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (enq) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (deq) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            unique case ({enq, deq})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (enq) mem[wptr] <= din;
    end

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        enq |-> !full);
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        deq |-> !empty);
endmodule

// File: rtl/mxs_short_unit.sv
module mxs_short_unit
    import mxs_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  opc_e              opc,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    always_comb begin
        unique case (opc)
            OPC_ADD:  y = a + b;
            OPC_SUB:  y = a - b;
            OPC_XOR:  y = a ^ b;
            default:  y = '0;
        endcase
    end
endmodule

// File: rtl/mxs_long_unit.sv
module mxs_long_unit #(
    parameter int DATA_W = 16,
    parameter int BUF_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [DATA_W-1:0] req_a,
    input  logic [DATA_W-1:0] req_b,
    output logic              rsp_valid,
    input  logic              rsp_take,
    output logic [DATA_W-1:0] rsp_data
);
    localparam int S1_W = 2 * DATA_W;
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    // first step: product, operand a carried alongside
    logic [DATA_W-1:0] prod;
    logic [S1_W-1:0]   s1_in, s1_out;
    logic              s1_full, s1_empty;
    // middle step: accumulate
    logic [DATA_W-1:0] s2_in, s2_out;
    logic              s2_full, s2_empty;
    logic              enq1, move;

    assign prod      = req_a * req_b;
    assign s1_in     = {req_a, prod};
    assign req_ready = !s1_full;
    assign enq1      = req_valid && req_ready;
    assign move      = !s1_empty && !s2_full;
    assign s2_in     = s1_out[DATA_W-1:0] + s1_out[S1_W-1:DATA_W];

    mxs_fifo #(.WIDTH(S1_W), .DEPTH(BUF_DEPTH)) u_buf1 (
        .clk(clk), .rst_n(rst_n),
        .enq(enq1), .din(s1_in), .full(s1_full),
        .deq(move), .dout(s1_out), .empty(s1_empty)
    );

    mxs_fifo #(.WIDTH(DATA_W), .DEPTH(BUF_DEPTH)) u_buf2 (
        .clk(clk), .rst_n(rst_n),
        .enq(move), .din(s2_in), .full(s2_full),
        .deq(rsp_take), .dout(s2_out), .empty(s2_empty)
    );

    // last step applied as the response is read
    assign rsp_valid = !s2_empty;
    assign rsp_data  = s2_out + ONE;
endmodule

// File: rtl/mixed_exec_stage.sv
module mixed_exec_stage
    import mxs_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BUF_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic [1:0]        op_code,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic              res_valid,
    input  logic              res_ready,
    output logic [DATA_W-1:0] res_data,
    output logic              busy
);
    seq_state_e        state, state_nx;
    opc_e              opc;
    logic              is_long;
    logic [DATA_W-1:0] short_y;
    logic              lu_req_valid, lu_req_ready;
    logic              lu_rsp_valid, lu_rsp_take;
    logic [DATA_W-1:0] lu_rsp_data;

    assign opc     = opc_e'(op_code);
    assign is_long = (opc == OPC_LONG);

    mxs_short_unit #(.DATA_W(DATA_W)) u_short (
        .opc(opc), .a(op_a), .b(op_b), .y(short_y)
    );

    mxs_long_unit #(.DATA_W(DATA_W), .BUF_DEPTH(BUF_DEPTH)) u_long (
        .clk(clk), .rst_n(rst_n),
        .req_valid(lu_req_valid), .req_ready(lu_req_ready),
        .req_a(op_a), .req_b(op_b),
        .rsp_valid(lu_rsp_valid), .rsp_take(lu_rsp_take),
        .rsp_data(lu_rsp_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_READY;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx     = state;
        op_ready     = 1'b0;
        res_valid    = 1'b0;
        res_data     = '0;
        lu_req_valid = 1'b0;
        lu_rsp_take  = 1'b0;
        unique case (state)
            ST_READY: begin
                if (is_long) begin
                    op_ready     = lu_req_ready;
                    lu_req_valid = op_valid;
                    if (op_valid && lu_req_ready) state_nx = ST_WAIT;   // ISSUE
                end else begin
                    op_ready  = res_ready;
                    res_valid = op_valid;
                    res_data  = short_y;
                end
            end
            ST_WAIT: begin
                res_valid   = lu_rsp_valid;
                res_data    = lu_rsp_data;
                lu_rsp_take = lu_rsp_valid && res_ready;
                if (lu_rsp_take) state_nx = ST_READY;                  // RETIRE
            end
            default: state_nx = ST_READY;
        endcase
    end

    assign busy = (state == ST_WAIT);

    assert_wait_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !op_ready);
    assert_issue_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && op_valid && op_ready && is_long) |-> (!res_valid ##1 busy));
    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && res_valid && !res_ready) |=> (busy && res_valid && $stable(res_data)));
    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && res_valid && res_ready) |=> !busy);
    assert_short_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !is_long) |-> (op_ready == res_ready));
endmodule

// File: tb/mixed_exec_stage_tb.sv
module mixed_exec_stage_tb_top;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic         op_ready;
    logic [1:0]   op_code = 2'b00;
    logic [W-1:0] op_a = '0, op_b = '0;
    logic         res_valid;
    logic         res_ready = 1'b0;
    logic [W-1:0] res_data;
    logic         busy;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // reference model state
    bit           m_busy = 1'b0;
    int           m_cnt = 0;
    logic [W-1:0] m_res = '0;

    always #5 clk = ~clk;

    mixed_exec_stage #(.DATA_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .op_valid(op_valid), .op_ready(op_ready), .op_code(op_code),
        .op_a(op_a), .op_b(op_b),
        .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
        .busy(busy)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] short_ref(input logic [1:0] oc, input logic [W-1:0] a, input logic [W-1:0] b);
        case (oc)
            2'b00:   return a + b;
            2'b01:   return a - b;
            default: return a ^ b;
        endcase
    endfunction

    function automatic logic [W-1:0] long_ref(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] t;
        t = a * b;
        t = t + a + W'(1);
        return t;
    endfunction

    task automatic step(input bit v, input logic [1:0] oc, input logic [W-1:0] a,
                        input logic [W-1:0] b, input bit rr);
        bit exp_val;
        bit exp_rdy;
        @(negedge clk);
        op_valid = v; op_code = oc; op_a = a; op_b = b; res_ready = rr;
        #1;
        chk("R8 busy", W'(busy), W'(m_busy));
        if (!m_busy) begin
            exp_rdy = (oc == 2'b11) ? 1'b1 : rr;
            exp_val = v && (oc != 2'b11);
            if (oc == 2'b11) begin
                chk("R4 op_ready", W'(op_ready), W'(exp_rdy));
                chk("R4 res_valid", W'(res_valid), W'(exp_val));
            end else begin
                chk("R3 op_ready", W'(op_ready), W'(exp_rdy));
                chk("R2 res_valid", W'(res_valid), W'(exp_val));
                if (exp_val) chk("R2 res_data", res_data, short_ref(oc, a, b));
            end
        end else begin
            exp_val = (m_cnt >= 1);
            chk("R5 op_ready", W'(op_ready), '0);
            chk("R6 res_valid", W'(res_valid), W'(exp_val));
            if (exp_val) begin
                if (!rr) chk("R7 res_data", res_data, m_res);
                else     chk("R6 res_data", res_data, m_res);
            end
        end
        if (!m_busy) begin
            if (v && oc == 2'b11) begin
                m_busy = 1'b1; m_cnt = 0; m_res = long_ref(a, b);
            end
        end else begin
            if (m_cnt >= 1 && rr) m_busy = 1'b0;
            m_cnt++;
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7));
        repeat (3) @(negedge clk);
        #1;
        chk("R1 busy", W'(busy), '0);
        chk("R1 res_valid", W'(res_valid), '0);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R1 busy", W'(busy), '0);
        chk("R1 res_valid", W'(res_valid), '0);

        // R2/R3: back-to-back short ops, handoff and acceptance in one cycle
        step(1, 2'b00, 16'hFFFF, 16'h0002, 1);
        step(1, 2'b01, 16'h0003, 16'h0005, 1);
        step(1, 2'b10, 16'hA5A5, 16'h0FF0, 1);
        step(1, 2'b00, 16'h1234, 16'h1111, 0);   // R3 stall
        step(1, 2'b00, 16'h1234, 16'h1111, 1);

        // R4/R6/R8: long op taken at once
        step(1, 2'b11, 16'h0103, 16'h0007, 1);
        step(1, 2'b00, 16'h0001, 16'h0001, 1);
        step(1, 2'b00, 16'h0001, 16'h0001, 1);
        step(1, 2'b00, 16'h0002, 16'h0002, 1);   // accepted right after retire

        // R7: stalled long result, then long op straight after retire
        step(1, 2'b11, 16'hFFFF, 16'hFFFF, 0);
        repeat (5) step(1, 2'b10, 16'h0F0F, 16'h00FF, 0);
        step(1, 2'b11, 16'h0002, 16'h0003, 1);
        step(1, 2'b11, 16'h8000, 16'h0002, 1);
        repeat (4) step(0, 2'b00, '0, '0, 1);

        // mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 4) != 0, 2'($urandom), W'($urandom), W'($urandom),
                 ($urandom % 3) != 0);
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule